// File: doc/BRIEF.md
# Shared PCI Interrupt Line Router

This block takes eight shared, level-sensitive PCI interrupt lines (called PIRQ A to H, indices 0 to 7) and one power-management interrupt level (the ACPI SCI). It steers them onto the sixteen inputs of a legacy programmable interrupt controller and onto the global system interrupt lines of an I/O APIC. Software writes a routing byte for each PIRQ and a select code for the SCI through a simple register port. All output levels are computed combinationally from the input levels and the stored routing state, so an input change shows on the outputs in the same cycle.

Each PIC output is the OR of every PIRQ that is connected to the PIC and whose routing byte names that output. If the SCI's selected line is below 16, the SCI is also ORed into that PIC output. On the APIC side the routing bytes play no part: PIRQ n always drives line 16+n, and the SCI is ORed into its selected line.

A separate combinational function tells the platform which PIRQ a device slot's INTx pin lands on. Slot 30 has a fixed mapping.

Top module: `irq_router`

## Requirements
- R1: After reset every routing byte reads 0x80, which means disconnected with IRQ field 0. The SCI select code reads 0. With no write since reset, no PIRQ level reaches any PIC output.
- R2: Register addresses 0 to 3 hold the routing bytes for PIRQ A to D, and addresses 4 to 7 hold those for PIRQ E to H. Address 8 holds the SCI select code in bits 2:0. A write with wrEn high takes effect at the next rising clock edge. rdData shows the addressed register combinationally, and bits 7:3 of address 8 read as 0.
- R3: In a routing byte, bits 3:0 give the PIC line number and bit 7 set disconnects that PIRQ from the PIC. PIC output k is the OR of the levels of all connected PIRQs whose field equals k.
- R4: APIC line 16+n equals the level of PIRQ n (ORed with the SCI if the SCI selects that line), whatever its routing byte holds.
- R5: SCI select codes 0, 1, 2, 3 and 4 pick lines 9, 10, 11, 20 and 21. The SCI level is ORed into that APIC line, and also into the PIC output of the same number when the number is below 16. Codes 5 to 7 route the SCI nowhere.
- R6: With all PIRQ levels low and the SCI low, every PIC and APIC output is low. Outputs follow input changes within the same cycle.
- R7: For any slot other than 30, the INTx mapping gives mapPirq = ((slot + intx) mod 4) + 4. INTx is encoded 0 to 3 for INTA to INTD.
- R8: For slot 30, INTA to INTD map to PIRQ E to H (mapPirq = intx + 4).
- R9: Writes to addresses 9 to 15 change no register, and those addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| pirqLevel | input | 8 | Levels of PIRQ A..H (bit n is PIRQ n) |
| sciLevel | input | 1 | SCI level |
| mapSlot | input | 5 | Device slot for the INTx mapping query |
| mapIntx | input | 2 | INTx pin (0 = INTA .. 3 = INTD) |
| mapPirq | output | 3 | PIRQ index that the queried slot/pin lands on |
| picLevel | output | 16 | Levels driven to the legacy PIC inputs |
| apicLevel | output | 24 | Levels driven to APIC lines 0..23 |

## Verification
The checker checks the following on every cycle:
- each connected, active PIRQ raises the PIC output its field names;
- every PIRQ is mirrored onto its fixed APIC line;
- all outputs go quiet when no input is asserted;
- reserved SCI codes route nothing;
- a register write lands one edge later;
- writes to unused addresses disturb no state.

The exact OR merging of several PIRQs onto one PIC line, the mapping of each SCI code to its line, the reset values seen through the read port and the slot mapping table can only be shown by the bench's scenarios, which compare them against an independent model.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  parameter int PIRQ_COUNT     = 8;
  parameter int PIC_LINES      = 16;
  parameter int APIC_LINES     = 24;
  parameter int APIC_PIRQ_BASE = 16;
  parameter int IRQ_FIELD_W    = 4;
  parameter int ROUTE_W        = 8;
  parameter int DISC_BIT       = 7;
  parameter int ADDR_W         = 4;
  parameter int SCI_SEL_W      = 3;
  parameter int LINE_W         = 5;
  parameter int SLOT_W         = 5;
  parameter int INTX_W         = 2;
  parameter int FIXED_SLOT     = 30;

  localparam int PIRQ_IDX_W = $clog2(PIRQ_COUNT);
  localparam int SCI_ADDR   = PIRQ_COUNT;
  localparam logic [ROUTE_W-1:0] ROUTE_RESET = ROUTE_W'(1) << DISC_BIT;

  typedef struct packed {
    logic [PIRQ_COUNT-1:0] routeWr;
    logic                  sciWr;
  } regStrobes_t;

  typedef struct packed {
    logic              valid;
    logic [LINE_W-1:0] line;
  } sciDest_t;

  function automatic sciDest_t sciDecode(logic [SCI_SEL_W-1:0] code);
    sciDest_t d;
    d.valid = 1'b1;
    case (code)
      3'd0:    d.line = LINE_W'(9);
      3'd1:    d.line = LINE_W'(10);
      3'd2:    d.line = LINE_W'(11);
      3'd3:    d.line = LINE_W'(20);
      3'd4:    d.line = LINE_W'(21);
      default: begin d.valid = 1'b0; d.line = '0; end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output regStrobes_t       strobes
);
  for (genvar n = 0; n < PIRQ_COUNT; n++) begin : g_dec
    assign strobes.routeWr[n] = wrEn && (wrAddr == ADDR_W'(n));
  end
  assign strobes.sciWr = wrEn && (wrAddr == ADDR_W'(SCI_ADDR));
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  regStrobes_t                         strobes,
  input  logic [ROUTE_W-1:0]                  wrData,
  input  logic [ADDR_W-1:0]                   rdAddr,
  output logic [ROUTE_W-1:0]                  rdData,
  input  logic [PIRQ_COUNT-1:0]               pirqLevel,
  input  logic                                sciLevel,
  output logic [PIC_LINES-1:0]                picLevel,
  output logic [APIC_LINES-1:0]               apicLevel,
  output logic [PIRQ_COUNT-1:0][ROUTE_W-1:0]  routeTable,
  output logic [SCI_SEL_W-1:0]                sciSel
);
  // routing state
  for (genvar n = 0; n < PIRQ_COUNT; n++) begin : g_route
    always_ff @(posedge clk) begin
      if (!rstN)                   routeTable[n] <= ROUTE_RESET;
      else if (strobes.routeWr[n]) routeTable[n] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              sciSel <= '0;
    else if (strobes.sciWr) sciSel <= wrData[SCI_SEL_W-1:0];
  end

  sciDest_t sciDest;
  assign sciDest = sciDecode(sciSel);

  // PIC side: one vote per PIRQ per line
  logic [PIC_LINES-1:0][PIRQ_COUNT-1:0] picVote;
  for (genvar k = 0; k < PIC_LINES; k++) begin : g_pic
    for (genvar n = 0; n < PIRQ_COUNT; n++) begin : g_vote
      assign picVote[k][n] = pirqLevel[n] & ~routeTable[n][DISC_BIT] &
                             (routeTable[n][IRQ_FIELD_W-1:0] == IRQ_FIELD_W'(k));
    end
    assign picLevel[k] = (|picVote[k]) |
                         (sciLevel & sciDest.valid & (sciDest.line == LINE_W'(k)));
  end

  // APIC side: fixed PIRQ lines plus SCI
  for (genvar g = 0; g < APIC_LINES; g++) begin : g_apic
    logic pirqPart;
    if (g >= APIC_PIRQ_BASE && g < APIC_PIRQ_BASE + PIRQ_COUNT) begin : g_fixed
      assign pirqPart = pirqLevel[g - APIC_PIRQ_BASE];
    end else begin : g_none
      assign pirqPart = 1'b0;
    end
    assign apicLevel[g] = pirqPart |
                          (sciLevel & sciDest.valid & (sciDest.line == LINE_W'(g)));
  end

  // read port
  always_comb begin
    rdData = '0;
    if (rdAddr < ADDR_W'(PIRQ_COUNT))
      rdData = routeTable[rdAddr[PIRQ_IDX_W-1:0]];
    else if (rdAddr == ADDR_W'(SCI_ADDR))
      rdData = ROUTE_W'(sciSel);
  end
endmodule

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import irq_route_pkg::*;
(
  input  logic [SLOT_W-1:0]     slot,
  input  logic [INTX_W-1:0]     intx,
  output logic [PIRQ_IDX_W-1:0] pirq
);
  logic [INTX_W-1:0] rot;
  assign rot = slot[INTX_W-1:0] + intx;   // modulo-4 wrap
  always_comb begin
    if (slot == SLOT_W'(FIXED_SLOT)) pirq = {1'b1, intx};
    else                             pirq = {1'b1, rot};
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_route_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [ROUTE_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [ROUTE_W-1:0]    rdData,
  input  logic [PIRQ_COUNT-1:0] pirqLevel,
  input  logic                  sciLevel,
  input  logic [SLOT_W-1:0]     mapSlot,
  input  logic [INTX_W-1:0]     mapIntx,
  output logic [PIRQ_IDX_W-1:0] mapPirq,
  output logic [PIC_LINES-1:0]  picLevel,
  output logic [APIC_LINES-1:0] apicLevel
);
  regStrobes_t                        strobes;
  logic [PIRQ_COUNT-1:0][ROUTE_W-1:0] routeTable;
  logic [SCI_SEL_W-1:0]               sciSel;

  irq_route_ctrl u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .strobes(strobes)
  );

  irq_route_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pirqLevel(pirqLevel),
    .sciLevel(sciLevel), .picLevel(picLevel), .apicLevel(apicLevel),
    .routeTable(routeTable), .sciSel(sciSel)
  );

  irq_slot_map u_map (
    .slot(mapSlot), .intx(mapIntx), .pirq(mapPirq)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_route_pkg::*;
(
  input logic                               clk,
  input logic                               rstN,
  input logic                               wrEn,
  input logic [ADDR_W-1:0]                  wrAddr,
  input logic [ROUTE_W-1:0]                 wrData,
  input logic [PIRQ_COUNT-1:0]              pirqLevel,
  input logic                               sciLevel,
  input logic [PIC_LINES-1:0]               picLevel,
  input logic [APIC_LINES-1:0]              apicLevel,
  input logic [PIRQ_COUNT-1:0][ROUTE_W-1:0] routeTable,
  input logic [SCI_SEL_W-1:0]               sciSel
);
  for (genvar n = 0; n < PIRQ_COUNT; n++) begin : g_per_pirq
    // R3: a connected, active PIRQ raises the PIC line its field names
    a_r3_pic_vote: assert property (@(posedge clk) disable iff (!rstN)
      (pirqLevel[n] && !routeTable[n][DISC_BIT]) |->
        picLevel[routeTable[n][IRQ_FIELD_W-1:0]]);
    // R4: fixed APIC mirror
    a_r4_apic_mirror: assert property (@(posedge clk) disable iff (!rstN)
      pirqLevel[n] |-> apicLevel[APIC_PIRQ_BASE + n]);
    a_r4_apic_low: assert property (@(posedge clk) disable iff (!rstN)
      (!pirqLevel[n] && !sciLevel) |-> !apicLevel[APIC_PIRQ_BASE + n]);
  end

  // R6: quiet inputs give quiet outputs
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (pirqLevel == '0 && !sciLevel) |-> (picLevel == '0 && apicLevel == '0));

  // R5: reserved SCI codes route nowhere
  a_r5_sci_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (sciSel > SCI_SEL_W'(4) && pirqLevel == '0) |->
      (picLevel == '0 && apicLevel == '0));

  // R2: a routing write lands one edge later
  a_r2_route_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr < ADDR_W'(PIRQ_COUNT)) |=>
      routeTable[$past(wrAddr[PIRQ_IDX_W-1:0])] == $past(wrData));

  // R9: unused addresses change nothing
  a_r9_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr > ADDR_W'(SCI_ADDR)) |=> ($stable(routeTable) && $stable(sciSel)));
endmodule

bind irq_router irq_router_chk u_chk (.*);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, wrEn, sciLevel;
  logic [3:0]  wrAddr, rdAddr;
  logic [7:0]  wrData, rdData, pirqLevel;
  logic [4:0]  mapSlot;
  logic [1:0]  mapIntx;
  logic [2:0]  mapPirq;
  logic [15:0] picLevel;
  logic [23:0] apicLevel;

  irq_router dut (.*);

  typedef struct packed {
    logic [15:0] pic;
    logic [23:0] apic;
    logic [7:0]  rd;
    logic [2:0]  map;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] mRoute [8];
  logic [2:0] mSci;

  function automatic int sciLine(logic [2:0] c);
    case (c)
      3'd0: return 9;
      3'd1: return 10;
      3'd2: return 11;
      3'd3: return 20;
      3'd4: return 21;
      default: return -1;
    endcase
  endfunction

  task automatic apply(input logic [7:0] pl, input logic sl, input logic [3:0] ra,
                       input int slot, input int ix, input string tag);
    expItem_t e;
    int ln;
    @(posedge clk); #1;
    pirqLevel = pl; sciLevel = sl; rdAddr = ra;
    mapSlot = 5'(slot); mapIntx = 2'(ix);
    e.pic = '0;
    for (int n = 0; n < 8; n++)
      if (pl[n] && !mRoute[n][7]) e.pic[mRoute[n][3:0]] = 1'b1;
    e.apic = {pl, 16'h0000};
    ln = sciLine(mSci);
    if (sl && ln >= 0) begin
      e.apic[ln] = 1'b1;
      if (ln < 16) e.pic[ln] = 1'b1;
    end
    if (ra < 8)       e.rd = mRoute[ra[2:0]];
    else if (ra == 8) e.rd = {5'b0, mSci};
    else              e.rd = 8'h00;
    e.map = (slot == 30) ? 3'(ix + 4) : 3'(((slot + ix) % 4) + 4);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    if (a < 8) mRoute[a[2:0]] = d;
    else if (a == 8) mSci = d[2:0];
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  // monitor: compare one item per cycle away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (picLevel !== e.pic || apicLevel !== e.apic || rdData !== e.rd || mapPirq !== e.map) begin
        errors++;
        $display("FAIL %s pic %h/%h apic %h/%h rd %h/%h map %0d/%0d (actual/expected)",
                 t, picLevel, e.pic, apicLevel, e.apic, rdData, e.rd, mapPirq, e.map);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; wrEn = 0; wrAddr = 0; wrData = 0; rdAddr = 0;
    pirqLevel = 0; sciLevel = 0; mapSlot = 0; mapIntx = 0;
    for (int n = 0; n < 8; n++) mRoute[n] = 8'h80;
    mSci = 3'd0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1: reset values, all PIRQs active but disconnected
    for (int a = 0; a <= 8; a++) apply(8'hFF, 1'b0, 4'(a), 0, 0, "R1");

    // R2/R3: routing with sharing on line 5
    regWrite(4'd0, 8'h05);
    regWrite(4'd1, 8'h05);
    regWrite(4'd4, 8'h03);
    regWrite(4'd7, 8'h0F);
    apply(8'h01, 0, 4'd0, 1, 1, "R3");
    apply(8'h02, 0, 4'd1, 2, 3, "R3");
    apply(8'h03, 0, 4'd4, 3, 2, "R3");
    apply(8'h10, 0, 4'd7, 4, 0, "R3");
    apply(8'h80, 0, 4'd2, 5, 1, "R3");
    apply(8'hFF, 0, 4'd3, 6, 2, "R3");
    regWrite(4'd8, 8'hFD);
    apply(8'h00, 0, 4'd8, 0, 0, "R2");
    regWrite(4'd8, 8'h00);
    mSci = 3'd0;
    // R3: disconnect bit on PIRQ B
    regWrite(4'd1, 8'h85);
    apply(8'h02, 0, 4'd1, 0, 0, "R3");
    apply(8'h03, 0, 4'd1, 0, 0, "R3");

    // R4: APIC mirror independent of routing
    for (int n = 0; n < 8; n++) apply(8'(1 << n), 0, 4'd0, 0, 0, "R4");

    // R6: same-cycle response, quiet
    apply(8'h11, 0, 4'd0, 7, 1, "R6");
    apply(8'h00, 0, 4'd0, 7, 1, "R6");
    apply(8'h11, 0, 4'd0, 7, 1, "R6");

    // R5: every SCI code
    for (int c = 0; c < 8; c++) begin
      regWrite(4'd8, 8'(c));
      apply(8'h00, 1, 4'd8, 0, 0, "R5");
      apply(8'h01, 1, 4'd8, 0, 0, "R5");
      apply(8'h00, 0, 4'd8, 0, 0, "R5");
    end

    // R9: unused addresses
    regWrite(4'd9, 8'h00);
    regWrite(4'd12, 8'h00);
    regWrite(4'd15, 8'h01);
    apply(8'hFF, 0, 4'd9, 0, 0, "R9");
    apply(8'hFF, 0, 4'd15, 0, 0, "R9");
    apply(8'hFF, 0, 4'd1, 0, 0, "R9");

    // R7/R8: slot mapping
    for (int s = 0; s < 32; s++)
      for (int i = 0; i < 4; i++)
        apply(8'h00, 0, 4'd0, s, i, (s == 30) ? "R8" : "R7");

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule